// File: doc/BRIEF.md
# TLB Array Load/Store Access Port

This block holds the storage of a 4-way, 32-set translation lookaside buffer and exposes both of its arrays to software through a 32-bit load/store window. One window reaches the tag side of each entry (virtual page number, valid flag, address-space identifier). The other window reaches the payload side (physical page number and the protection, page-size, cacheable, dirty and shared attributes). Management code uses plain loads and stores to inspect, fill or invalidate entries without going through the translation path.

The request address carries the window select in its top byte, the set index in bits 16..12 and the way in bits 9..8. When the hash enable input is high, the set actually used is the index field XORed with the low five bits of the current address-space identifier. This matches the set placement used by a hashed lookup. The valid flag is a single stored bit per entry that both windows read and write.

Requests use a valid/ready handshake. Ready is always high, and every accepted request gets exactly one response cycle. Accesses that are illegal (wrong size, user mode, instruction fetch or outside both windows) are flagged, return zero and change nothing.

Top module: `tlb_window_port`

## Requirements
- R1: A legal access with address bits 31..24 = 0xF2 reaches the tag array, and one with 0xF3 reaches the payload array. Any other value in that byte is flagged as an error.
- R2: Address bits 16..12 select one of 32 sets and bits 9..8 select one of 4 ways. The 128 entries are stored independently.
- R3: When `hash_en` is 1, the set used is the index field XOR `cur_asid[4:0]`. When it is 0, the index field is used directly.
- R4: Tag word layout: VPN in bits 31..17, valid in bit 8, ASID in bits 7..0. Bits 16..9 are ignored on write and read as zero.
- R5: Payload word layout: PPN in bits 31..10, valid in bit 8, PR in bits 6..5, SZ in bit 4, C in bit 3, D in bit 2, SH in bit 1. Bits 9, 7 and 0 are ignored on write and read as zero.
- R6: The valid bit of an entry is one stored bit. A write through either window changes it, and a read through either window shows it. A payload write leaves VPN and ASID unchanged, and a tag write leaves PPN and the attributes unchanged.
- R7: Only `req_size` = 2'b10 (32-bit) is legal. Any other size raises `rsp_err`, returns zero data and leaves the arrays unchanged.
- R8: An access with `req_priv` = 0 (user mode) raises `rsp_err`, returns zero and leaves the arrays unchanged.
- R9: An access with `req_ifetch` = 1 raises `rsp_err`, returns zero and leaves the arrays unchanged.
- R10: After reset, every entry reads as all zeros through both windows, with its valid bit clear.
- R11: `req_ready` is always 1. A request accepted on a clock edge produces `rsp_valid` = 1 for exactly the following cycle, and there is no response without a request. A legal write responds with zero data and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address (window, set, way fields) |
| req_wdata | input | 32 | Store data |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| req_priv | input | 1 | Requester is in privileged mode |
| req_ifetch | input | 1 | Request is an instruction fetch |
| cur_asid | input | 8 | Current address-space identifier |
| hash_en | input | 1 | Hash the set index with the ASID |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Load data, zero for stores and errors |
| rsp_err | output | 1 | Access was rejected |

## Verification
A wrongly stored or wrongly routed entry stays hidden until software reads that set and way back. The bench therefore follows every store with a load of the target entry and of its neighbours in set and way. A fault in the shared valid bit shows only on a cross-window read, so each valid change is read back through the opposite window. A rejected store that still wrote something is exposed by re-reading the entry one transaction later. A hash fault appears as data landing in the unhashed set, so hashed writes are read back with hashing disabled.

// File: rtl/tlb_window_port.sv
module tlb_window_port #(
  parameter int SETS = 32,
  parameter int WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [1:0]  req_size,
  input  logic        req_priv,
  input  logic        req_ifetch,
  input  logic [7:0]  cur_asid,
  input  logic        hash_en,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err
);
  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int ENT_W   = IDX_W + WAY_W;
  localparam int VPN_W   = 15;
  localparam int PPN_W   = 22;
  localparam int ATR_W   = 6;
  localparam logic [7:0] TAG_WIN = 8'hF2;
  localparam logic [7:0] PAY_WIN = 8'hF3;
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [VPN_W-1:0] vpn_q  [ENTRIES];
  logic [7:0]       asid_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  logic [ATR_W-1:0] atr_q  [ENTRIES];
  logic [ENTRIES-1:0] v_q;

  logic             hit_tag, hit_pay, legal;
  logic [IDX_W-1:0] set_sel;
  logic [ENT_W-1:0] ent;
  logic [31:0]      tag_word, pay_word;

  assign req_ready = 1'b1;
  assign hit_tag   = req_addr[31:24] == TAG_WIN;
  assign hit_pay   = req_addr[31:24] == PAY_WIN;
  assign legal     = (hit_tag || hit_pay) && req_size == SZ_WORD && req_priv && !req_ifetch;
  assign set_sel   = req_addr[12 +: IDX_W] ^ (hash_en ? cur_asid[IDX_W-1:0] : '0);
  assign ent       = {set_sel, req_addr[8 +: WAY_W]};
  assign tag_word  = {vpn_q[ent], 8'h00, v_q[ent], asid_q[ent]};
  assign pay_word  = {ppn_q[ent], 1'b0, v_q[ent], 1'b0, atr_q[ent], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        ppn_q[i]  <= '0;
        atr_q[i]  <= '0;
      end
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !legal;
      rsp_rdata <= (req_valid && legal && !req_write) ? (hit_tag ? tag_word : pay_word) : '0;
      if (req_valid && legal && req_write) begin
        v_q[ent] <= req_wdata[8];
        if (hit_tag) begin
          vpn_q[ent]  <= req_wdata[31:17];
          asid_q[ent] <= req_wdata[7:0];
        end else begin
          ppn_q[ent] <= req_wdata[31:10];
          atr_q[ent] <= req_wdata[6:1];
        end
      end
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R11
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (rsp_valid && rsp_rdata == 32'h0)); // R7
  AST_SIZE_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_size != 2'b10) |=> rsp_err); // R7
  AST_USER_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_priv) |=> rsp_err); // R8
  AST_FETCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ifetch) |=> rsp_err); // R9
  AST_WINDOW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:24] != 8'hF2 && req_addr[31:24] != 8'hF3) |=> rsp_err); // R1
  AST_BAD_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_size != 2'b10 || !req_priv || req_ifetch)) |=> $stable(v_q)); // R7
endmodule

// File: tb/tlb_window_port_tb.sv
`timescale 1ns/1ps
module tlb_window_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b1, req_ifetch = 1'b0, hash_en = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_size = 2'b10;
  logic [7:0]  cur_asid = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic last_vld;

  always #2.5 clk = ~clk;

  tlb_window_port dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
    .req_priv(req_priv), .req_ifetch(req_ifetch), .cur_asid(cur_asid), .hash_en(hash_en),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

  function automatic logic [31:0] ta(input int s, input int w);
    return 32'hF200_0000 | (s << 12) | (w << 8);
  endfunction
  function automatic logic [31:0] pa(input int s, input int w);
    return 32'hF300_0000 | (s << 12) | (w << 8);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input logic pr, input logic fe,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    req_size = sz; req_priv = pr; req_ifetch = fe;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err; last_vld = rsp_valid;
    req_valid = 0; req_write = 0; req_size = 2'b10; req_priv = 1; req_ifetch = 0;
  endtask

  task automatic rd_ok(input string tag, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d; logic e;
    access(0, a, 0, 2'b10, 1, 0, d, e);
    chk(tag, d, exp);
    chk({tag, " err"}, {31'h0, e}, 32'h0);
  endtask

  task automatic wr_ok(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    access(1, a, d, 2'b10, 1, 0, r, e);
    chk("R11 write rsp data", r, 32'h0);
    chk("R11 write rsp err", {31'h0, e}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R11 no rsp after reset", {31'h0, rsp_valid}, 32'h0);
    chk("R11 ready high", {31'h0, req_ready}, 32'h1);
    rd_ok("R10 tag 0/0", ta(0, 0), 32'h0);
    rd_ok("R10 tag 31/3", ta(31, 3), 32'h0);
    rd_ok("R10 pay 17/1", pa(17, 1), 32'h0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    req_valid = 1; req_addr = ta(1, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R11 rsp one cycle after", {31'h0, rsp_valid}, 32'h1);
    @(negedge clk);
    chk("R11 rsp lasts one cycle", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic t_tag_array;
    wr_ok(ta(5, 2), 32'hB4B7_FF3C);
    rd_ok("R4 tag layout", ta(5, 2), 32'hB4B6_013C);
    rd_ok("R2 other way", ta(5, 1), 32'h0);
    rd_ok("R2 other set", ta(4, 2), 32'h0);
  endtask

  task automatic t_pay_array;
    wr_ok(pa(5, 2), 32'h1234_57FF);
    rd_ok("R5 payload layout", pa(5, 2), 32'h1234_557E);
    rd_ok("R1 R6 tag side intact", ta(5, 2), 32'hB4B6_013C);
    wr_ok(pa(5, 2), 32'h1234_547E);
    rd_ok("R6 clear via payload", ta(5, 2), 32'hB4B6_003C);
    wr_ok(ta(5, 2), 32'hB4B6_013C);
    rd_ok("R6 set via tag", pa(5, 2), 32'h1234_557E);
  endtask

  task automatic t_hash;
    hash_en = 1; cur_asid = 8'h23;
    wr_ok(ta(6, 0), 32'h0002_0111);
    hash_en = 0;
    rd_ok("R3 hashed set 5", ta(5, 0), 32'h0002_0111);
    rd_ok("R3 raw set 6 empty", ta(6, 0), 32'h0);
    hash_en = 1;
    rd_ok("R3 hashed read back", ta(6, 0), 32'h0002_0111);
    cur_asid = 8'h20;
    rd_ok("R3 asid low bits zero", ta(6, 0), 32'h0);
    hash_en = 0; cur_asid = 8'h00;
  endtask

  task automatic t_errors;
    logic [31:0] d; logic e;
    access(1, ta(5, 2), 32'h0, 2'b01, 1, 0, d, e);
    chk("R7 half write err", {31'h0, e}, 32'h1);
    rd_ok("R7 half write no effect", ta(5, 2), 32'hB4B6_013C);
    access(0, pa(5, 2), 32'h0, 2'b00, 1, 0, d, e);
    chk("R7 byte read err", {31'h0, e}, 32'h1);
    chk("R7 byte read zero", d, 32'h0);
    access(0, ta(5, 2), 32'h0, 2'b10, 0, 0, d, e);
    chk("R8 user read err", {31'h0, e}, 32'h1);
    chk("R8 user read zero", d, 32'h0);
    access(1, pa(5, 2), 32'h0, 2'b10, 0, 0, d, e);
    rd_ok("R8 user write no effect", pa(5, 2), 32'h1234_557E);
    access(0, ta(5, 2), 32'h0, 2'b10, 1, 1, d, e);
    chk("R9 fetch err", {31'h0, e}, 32'h1);
    chk("R9 fetch zero", d, 32'h0);
    access(1, ta(5, 2), 32'h0, 2'b10, 1, 1, d, e);
    rd_ok("R9 fetch write no effect", ta(5, 2), 32'hB4B6_013C);
    access(1, 32'hF400_5200, 32'h0, 2'b10, 1, 0, d, e);
    chk("R1 outside window err", {31'h0, e}, 32'h1);
    rd_ok("R1 outside window no effect", ta(5, 2), 32'hB4B6_013C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_timing;
    t_tag_array;
    t_pay_array;
    t_hash;
    t_errors;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule